// File: doc/BRIEF.md
# Weighted-Average Defuzzifier

This block turns a set of output membership functions into one crisp value. Each function arrives as one pair: a position `x` and a weight `w`. When the set uses the weighted plateau average, `x` is the plateau midpoint and `w` is the plateau height. The block multiplies each pair and adds the product to a weighted sum. It adds the weight alone to a second sum. After the pair flagged as last, it divides the weighted sum by the weight sum once. A multi-cycle restoring divider does this division. The result comes out with a one-cycle done pulse.

The multiplier and adder form the only path that must finish in one cycle. The divider works once per set, so it can run slowly. Both sums are cleared when the last pair is taken, so the next set can stream in while the divider is still working. Three parameters can swap in cheaper approximate arithmetic, and all three default to exact:
- `OR_LOW_BITS` forms the low bits of each accumulator adder with a bitwise OR.
- `ROW_SKIP` drops low partial-product rows from the multiplier.
- `COL_SKIP` drops low product columns from the multiplier.

Control is a three-state machine:
- `ST_COLLECT` takes pairs.
- A last pair with a non-zero weight sum moves it to `ST_DIVIDE`. When the quotient is ready (transition *quotient ready*), it returns to `ST_COLLECT` and emits the result.
- A last pair whose weight sum is zero moves it to `ST_ZERO`. From there it returns to `ST_COLLECT` after one cycle (transition *zero emitted*) and emits zero with the error flag.

Top module: `wavg_defuzzifier`

## Requirements
- R1: After reset, `out_done`, `out_zero_err` and `out_value` are all 0.
- R2: With the default exact arithmetic, the result of a set is floor(Σ(x·w) / Σw), taken over every pair of the set. `x` is the multiplicand and `w` is the multiplier. A quotient above 2^DATA_W−1 is clamped to all ones.
- R3: A pair is taken only in a cycle where `in_valid` is 1. When `in_valid` is 0, the values on `in_x`, `in_w` and `in_last` have no effect on any result.
- R4: Both sums return to zero on the edge that takes a last pair. Pairs of the next set may be streamed from the very next cycle, while the division is still running, and are not mixed with the finished set.
- R5: For a set with a non-zero weight sum, `out_done` is high for exactly one cycle. It rises on the (NW+1)-th rising edge after the edge that takes the last pair, where NW = 2·DATA_W + ceil(log2(MAX_TERMS)). `out_value` holds until the next done.
- R6: If the weight sum of a set is zero, the block emits `out_value` = 0 with `out_zero_err` = 1. In this case `out_done` rises on the first edge after the edge that takes the last pair.
- R7: `out_zero_err` returns to 0 with the next result whose weight sum is non-zero.
- R8: A set of a single pair with a non-zero weight yields that pair's `x`.
- R9: A set of MAX_TERMS pairs at full scale (x = w = 2^DATA_W−1) produces no overflow in either sum and yields 2^DATA_W−1.
- R10: With `OR_LOW_BITS` = L > 0, each accumulator adder works as follows:
  - Its low L sum bits are the OR of the operands' low L bits.
  - The upper part adds the operands' upper bits, plus a carry-in equal to the AND of the two operand bits at position L−1.
  - The multiplier sums only rows j ≥ `ROW_SKIP`, where row j is `x`·2^j gated by bit j of `w`.
  - Each row has its bits below position `COL_SKIP` cleared.
  - The quotient is the floor of the approximate sums, clamped as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies the pair on `in_x`/`in_w` |
| in_last | input | 1 | Marks the final pair of a set (used only with `in_valid`) |
| in_x | input | DATA_W | Membership function position (plateau midpoint) |
| in_w | input | DATA_W | Membership function weight (plateau height) |
| out_done | output | 1 | One-cycle pulse: a result is on `out_value` |
| out_value | output | DATA_W | Crisp output of the last completed set |
| out_zero_err | output | 1 | The last completed set had a zero weight sum |

## Verification
A non-zero set's result is due NW+1 edges after the edge that takes its last pair; with the defaults that is 21 edges. A zero-weight set's result is due one edge after. The driver reads a cycle counter when it presents a last pair and stores the due cycle next to the expected value and flag. The monitor flags a done that arrives early, arrives late, lasts more than one cycle, or appears with nothing expected. Last pairs are held back until the previous result has come out, while ordinary pairs are streamed into the division window to show that the sums are independent.

// File: rtl/dfz_pkg.sv
package dfz_pkg;

    typedef enum logic [1:0] {
        ST_COLLECT = 2'd0,
        ST_DIVIDE  = 2'd1,
        ST_ZERO    = 2'd2
    } dfz_state_e;

endpackage

// File: rtl/dfz_or_low_adder.sv
module dfz_or_low_adder #(
    parameter int W   = 16,
    parameter int LOW = 0
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W:0]   sum
);

    generate
        if (LOW == 0) begin : g_exact
            assign sum = {1'b0, a} + {1'b0, b};
        end else begin : g_or_low
            localparam int HI_W = W - LOW;
            logic [LOW-1:0] low_bits;
            logic           carry_in;
            logic [HI_W:0]  high_bits;

            assign low_bits  = a[LOW-1:0] | b[LOW-1:0];
            assign carry_in  = a[LOW-1] & b[LOW-1];
            assign high_bits = {1'b0, a[W-1:LOW]} + {1'b0, b[W-1:LOW]}
                             + {{HI_W{1'b0}}, carry_in};
            assign sum = {high_bits, low_bits};
        end
    endgenerate

endmodule

// File: rtl/dfz_trunc_array_mult.sv
module dfz_trunc_array_mult #(
    parameter int DW       = 8,
    parameter int ROW_SKIP = 0,
    parameter int COL_SKIP = 0
) (
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    output logic [2*DW-1:0] p
);

    localparam int PW = 2 * DW;
    localparam logic [PW-1:0] COL_MASK = {PW{1'b1}} << COL_SKIP;

    logic [PW-1:0] row   [DW];
    logic [PW-1:0] chain [DW+1];

    assign chain[0] = '0;

    generate
        for (genvar j = 0; j < DW; j++) begin : g_row
            if (j < ROW_SKIP) begin : g_drop
                assign row[j] = '0;
            end else begin : g_keep
                assign row[j] = b[j] ? (({{DW{1'b0}}, a} << j) & COL_MASK) : '0;
            end
            assign chain[j+1] = chain[j] + row[j];
        end
    endgenerate

    assign p = chain[DW];

endmodule

// File: rtl/dfz_restoring_div.sv
module dfz_restoring_div #(
    parameter int NW = 20,
    parameter int DNW = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [NW-1:0]  num,
    input  logic [DNW-1:0] den,
    output logic           busy,
    output logic           fin,
    output logic [NW-1:0]  quo
);

    localparam int CNT_W = $clog2(NW + 1);

    logic [DNW-1:0] rem_q;
    logic [DNW-1:0] den_q;
    logic [NW-1:0]  quo_q;
    logic [CNT_W-1:0] cnt_q;
    logic [DNW:0]   shifted;
    logic [DNW+1:0] diff;
    logic           fits;

    always_comb begin
        shifted = {rem_q, quo_q[NW-1]};
        diff    = {1'b0, shifted} - {2'b00, den_q};
        fits    = ~diff[DNW+1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            den_q <= '0;
            quo_q <= '0;
            cnt_q <= '0;
            busy  <= 1'b0;
            fin   <= 1'b0;
        end else if (start) begin
            rem_q <= '0;
            den_q <= den;
            quo_q <= num;
            cnt_q <= CNT_W'(NW);
            busy  <= 1'b1;
            fin   <= 1'b0;
        end else if (busy) begin
            rem_q <= fits ? diff[DNW-1:0] : shifted[DNW-1:0];
            quo_q <= {quo_q[NW-2:0], fits};
            cnt_q <= cnt_q - CNT_W'(1);
            if (cnt_q == CNT_W'(1)) begin
                busy <= 1'b0;
                fin  <= 1'b1;
            end
        end else begin
            fin <= 1'b0;
        end
    end

    assign quo = quo_q;

    // R2: a finished restoring division leaves a remainder below the divisor
    a_r2_rem_below_den: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> (rem_q < den_q));

    // R5: a new division is never launched over a running one
    a_r5_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

    // R5: the finish flag is a single-cycle pulse
    a_r5_fin_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !fin);

endmodule

// File: rtl/wavg_defuzzifier.sv
module wavg_defuzzifier #(
    parameter int DATA_W      = 8,
    parameter int MAX_TERMS   = 16,
    parameter int OR_LOW_BITS = 0,
    parameter int ROW_SKIP    = 0,
    parameter int COL_SKIP    = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic [DATA_W-1:0] in_x,
    input  logic [DATA_W-1:0] in_w,
    output logic              out_done,
    output logic [DATA_W-1:0] out_value,
    output logic              out_zero_err
);
    import dfz_pkg::*;

    localparam int GROW   = $clog2(MAX_TERMS);
    localparam int PROD_W = 2 * DATA_W;
    localparam int SUMX_W = PROD_W + GROW;
    localparam int SUMW_W = DATA_W + GROW;

    dfz_state_e state_q, state_d;

    logic [PROD_W-1:0] prod;
    logic [SUMX_W-1:0] acc_x_q;
    logic [SUMW_W-1:0] acc_w_q;
    logic [SUMX_W:0]   add_x;
    logic [SUMW_W:0]   add_w;
    logic              take;
    logic              take_last;
    logic              den_zero;
    logic              div_start;
    logic              div_busy;
    logic              div_fin;
    logic [SUMX_W-1:0] div_quo;
    logic [DATA_W-1:0] quo_clamped;

    dfz_trunc_array_mult #(
        .DW       (DATA_W),
        .ROW_SKIP (ROW_SKIP),
        .COL_SKIP (COL_SKIP)
    ) u_mult (
        .a (in_x),
        .b (in_w),
        .p (prod)
    );

    dfz_or_low_adder #(
        .W   (SUMX_W),
        .LOW (OR_LOW_BITS)
    ) u_add_x (
        .a   (acc_x_q),
        .b   ({{GROW{1'b0}}, prod}),
        .sum (add_x)
    );

    dfz_or_low_adder #(
        .W   (SUMW_W),
        .LOW (OR_LOW_BITS)
    ) u_add_w (
        .a   (acc_w_q),
        .b   ({{GROW{1'b0}}, in_w}),
        .sum (add_w)
    );

    assign take      = in_valid;
    assign take_last = in_valid && in_last && (state_q == ST_COLLECT);
    assign den_zero  = (add_w[SUMW_W-1:0] == '0);
    assign div_start = take_last && !den_zero;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_x_q <= '0;
            acc_w_q <= '0;
        end else if (take) begin
            if (in_last) begin
                acc_x_q <= '0;
                acc_w_q <= '0;
            end else begin
                acc_x_q <= add_x[SUMX_W-1:0];
                acc_w_q <= add_w[SUMW_W-1:0];
            end
        end
    end

    dfz_restoring_div #(
        .NW  (SUMX_W),
        .DNW (SUMW_W)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .num   (add_x[SUMX_W-1:0]),
        .den   (add_w[SUMW_W-1:0]),
        .busy  (div_busy),
        .fin   (div_fin),
        .quo   (div_quo)
    );

    assign quo_clamped = (|div_quo[SUMX_W-1:DATA_W]) ? {DATA_W{1'b1}}
                                                     : div_quo[DATA_W-1:0];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COLLECT: begin
                if (take_last) begin
                    state_d = den_zero ? ST_ZERO : ST_DIVIDE;
                end
            end
            ST_DIVIDE: begin
                if (div_fin) begin
                    state_d = ST_COLLECT;
                end
            end
            ST_ZERO: begin
                state_d = ST_COLLECT;
            end
            default: state_d = ST_COLLECT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_COLLECT;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_done     <= 1'b0;
            out_value    <= '0;
            out_zero_err <= 1'b0;
        end else begin
            out_done <= 1'b0;
            unique case (state_q)
                ST_DIVIDE: begin
                    if (div_fin) begin
                        out_done     <= 1'b1;
                        out_value    <= quo_clamped;
                        out_zero_err <= 1'b0;
                    end
                end
                ST_ZERO: begin
                    out_done     <= 1'b1;
                    out_value    <= '0;
                    out_zero_err <= 1'b1;
                end
                ST_COLLECT: begin
                end
                default: begin
                end
            endcase
        end
    end

    // R9: neither running sum carries out of its width
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (!add_x[SUMX_W] && !add_w[SUMW_W]));

    // R4: both sums are zero right after a last pair is taken
    a_r4_sums_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last) |=> (acc_x_q == '0 && acc_w_q == '0));

    // R5: the done flag lasts a single cycle
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |=> !out_done);

    // R6: an error result always carries the value zero
    a_r6_zero_value: assert property (@(posedge clk) disable iff (!rst_n)
        (out_done && out_zero_err) |-> (out_value == '0));

    // R3: a last pair is offered only while no result is pending
    a_r3_last_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last) |-> (state_q == ST_COLLECT && !div_busy));

    // R5: the divider reports completion only in the divide state
    a_r5_fin_in_divide: assert property (@(posedge clk) disable iff (!rst_n)
        div_fin |-> (state_q == ST_DIVIDE));

endmodule

// File: tb/wavg_defuzzifier_bench.sv
`timescale 1ns/1ps
module wavg_defuzzifier_bench;

    localparam int DW    = 8;
    localparam int TERMS = 16;
    localparam int NW    = 2 * DW + $clog2(TERMS);
    localparam int LAT   = NW + 2;   // from the driving negedge to the negedge that sees done

    typedef struct {
        int    value;
        int    err;
        int    due;
        string req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_last = 1'b0;
    logic [DW-1:0] in_x = '0;
    logic [DW-1:0] in_w = '0;
    logic          out_done;
    logic [DW-1:0] out_value;
    logic          out_zero_err;

    logic          a_valid = 1'b0;
    logic          a_last = 1'b0;
    logic [7:0]    a_x = '0;
    logic [7:0]    a_w = '0;
    logic          a_done;
    logic [7:0]    a_value;
    logic          a_err;

    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    bit   finished = 1'b0;
    bit   prev_done = 1'b0;
    exp_t sbq[$];
    longint sum_x = 0;
    longint sum_w = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wavg_defuzzifier #(.DATA_W(DW), .MAX_TERMS(TERMS)) u_wavg_defuzzifier (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
        .in_x(in_x), .in_w(in_w), .out_done(out_done),
        .out_value(out_value), .out_zero_err(out_zero_err)
    );

    wavg_defuzzifier #(.DATA_W(8), .MAX_TERMS(4), .OR_LOW_BITS(3),
                       .ROW_SKIP(2), .COL_SKIP(3)) u_approx (
        .clk(clk), .rst_n(rst_n), .in_valid(a_valid), .in_last(a_last),
        .in_x(a_x), .in_w(a_w), .out_done(a_done),
        .out_value(a_value), .out_zero_err(a_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // monitor: pops expected results as the design emits them
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_done && prev_done)
                check(1'b0, "R5", "done longer than one cycle", 1, 0);
            if (out_done) begin
                if (sbq.size() == 0) begin
                    check(1'b0, "R5", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    check(out_value == e.value, e.req, "value", out_value, e.value);
                    check(out_zero_err == e.err, e.req, "error flag", out_zero_err, e.err);
                    check(cyc == e.due, "R5", "done cycle", cyc, e.due);
                end
            end else if (sbq.size() != 0 && cyc > sbq[0].due) begin
                exp_t e;
                e = sbq.pop_front();
                check(1'b0, "R5", "done missing", cyc, e.due);
            end
            prev_done = out_done;
        end
    end

    // driver: presents one pair, and on a last pair queues the expected result
    task automatic send(input int x, input int w, input bit last, input string req);
        if (last) begin
            while (sbq.size() != 0) @(negedge clk);
        end
        in_valid = 1'b1;
        in_last  = last;
        in_x     = DW'(x);
        in_w     = DW'(w);
        sum_x += longint'(x) * longint'(w);
        sum_w += longint'(w);
        if (last) begin
            exp_t e;
            longint q;
            e.req = req;
            if (sum_w == 0) begin
                e.value = 0; e.err = 1; e.due = cyc + 2;   // R6 timing
            end else begin
                q = sum_x / sum_w;
                if (q > 255) q = 255;
                e.value = int'(q); e.err = 0; e.due = cyc + LAT;
            end
            sbq.push_back(e);
            sum_x = 0;
            sum_w = 0;
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    // R3: idle cycles with junk on the data and last lines
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b0;
            in_last  = 1'($urandom_range(0, 1));
            in_x     = DW'($urandom);
            in_w     = DW'($urandom);
            @(negedge clk);
        end
        in_last = 1'b0;
    endtask

    function automatic longint or_low_add(input longint a, input longint b,
                                          input int w, input int l);
        longint lo, hi, cin;
        if (l == 0) return (a + b) & ((longint'(1) << w) - 1);
        lo  = (a | b) & ((longint'(1) << l) - 1);
        cin = ((a >> (l - 1)) & (b >> (l - 1))) & 1;
        hi  = (a >> l) + (b >> l) + cin;
        return ((hi << l) | lo) & ((longint'(1) << w) - 1);
    endfunction

    function automatic longint skip_mult(input longint a, input longint b,
                                         input int rs, input int cs);
        longint p;
        p = 0;
        for (int j = rs; j < 8; j++)
            if (((b >> j) & 1) == 1)
                p += (a << j) & ~((longint'(1) << cs) - 1);
        return p & 16'hFFFF;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "R5", "watchdog expired", cyc, 0);
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int ax[3];
        int aw[3];
        longint mx, mw, q;
        int waited;
        ax = '{13, 200, 91};
        aw = '{7, 9, 6};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_done == 1'b0, "R1", "done after reset", out_done, 0);
        check(out_zero_err == 1'b0, "R1", "error after reset", out_zero_err, 0);
        check(out_value == '0, "R1", "value after reset", out_value, 0);

        // R2: basic weighted average, 430/8 -> 53
        send(10, 3, 0, "R2");
        send(200, 1, 0, "R2");
        send(50, 4, 1, "R2");

        // R3: gaps with junk between pairs
        send(120, 2, 0, "R3");
        idle(4);
        send(30, 6, 0, "R3");
        idle(3);
        send(255, 1, 1, "R3");
        idle(2);

        // R8: a single pair
        send(77, 5, 1, "R8");

        // R6: zero weights everywhere
        send(100, 0, 0, "R6");
        send(30, 0, 1, "R6");

        // R7: the flag clears with a good set
        send(20, 2, 0, "R7");
        send(40, 2, 1, "R7");

        // R9: full scale set
        for (int i = 0; i < TERMS - 1; i++) send(255, 255, 0, "R9");
        send(255, 255, 1, "R9");

        // R4: the next set streams while the previous one divides
        send(5, 1, 1, "R4");
        send(90, 3, 0, "R4");
        send(10, 9, 0, "R4");
        send(60, 4, 0, "R4");
        send(200, 2, 1, "R4");

        // R2: assorted sets
        for (int s = 0; s < 6; s++) begin
            int n;
            n = $urandom_range(1, TERMS);
            for (int i = 0; i < n; i++) begin
                send($urandom_range(0, 255), $urandom_range(1, 255), i == n - 1, "R2");
                if ((i % 3) == 1) idle(1);
            end
        end
        while (sbq.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);

        // R10: approximate arithmetic instance
        mx = 0; mw = 0;
        for (int i = 0; i < 3; i++) begin
            mx = or_low_add(mx, skip_mult(ax[i], aw[i], 2, 3), 18, 3);
            mw = or_low_add(mw, aw[i], 10, 3);
            a_valid = 1'b1;
            a_last  = (i == 2);
            a_x     = 8'(ax[i]);
            a_w     = 8'(aw[i]);
            @(negedge clk);
        end
        a_valid = 1'b0;
        a_last  = 1'b0;
        q = (mw == 0) ? 0 : mx / mw;
        if (q > 255) q = 255;
        waited = 0;
        while (!a_done && waited < 100) begin
            @(negedge clk);
            waited++;
        end
        check(a_done == 1'b1, "R10", "approximate done", a_done, 1);
        check(a_value == 8'(q), "R10", "approximate value", a_value, q);
        check(a_err == (mw == 0), "R10", "approximate error flag", a_err, mw == 0);

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule